// File: doc/BRIEF.md
# Disc interface interrupt register block

This block is the interrupt-facing register set of a disc drive interface. It holds a status register and a cover register. The status register carries three interrupt sources, each with a pending bit and an enable bit: drive error, transfer complete and break. It also carries a stop request bit. The cover register follows the drive lid and raises its own interrupt whenever the lid opens or closes. A small configuration register is mapped beside them. Event pulses from the drive side set the pending bits. Software clears a pending bit by writing 1 to it.

Software reaches the block through a plain 32-bit register port. A write strobe with address and data commits on the clock edge. Read data is combinational from the address. The four enabled sources are merged into one registered interrupt line for the processor.

Top module: `disc_irq_regs`

## Requirements
- R1: Status register (offset 0x00) reads bit 0 stop request, bit 1 error enable, bit 2 error pending, bit 3 transfer-complete enable, bit 4 transfer-complete pending, bit 5 break enable, bit 6 break pending. Bits 31..7 read zero.
- R2: A status write loads bits 0, 1, 3 and 5 from the written data on the clock edge.
- R3: Writing 1 to status bit 2, 4 or 6 clears that pending bit. Writing 0 leaves it as it was.
- R4: Cover register (offset 0x04) reads bit 0 lid open, bit 1 cover enable, bit 2 cover pending, and bits 31..3 read zero. A write loads only bit 1 and clears bit 2 when that bit is written as 1. Bit 0 ignores written data.
- R5: When the lid input differs from the stored lid bit, the next edge copies the input into bit 0 and sets cover pending.
- R6: The first edge after reset release loads the lid bit from the lid input without setting cover pending.
- R7: The interrupt output is high one cycle after any of the four pending bits is set together with its enable bit. It is low one cycle after no such pair remains.
- R8: The configuration register (offset 0x24) stores the low 8 written bits and reads its upper bits as zero.
- R9: A drive event and a software clear of the same pending bit in the same cycle leave the bit set.
- R10: Reads of any other offset return zero. Writes to any other offset change no register.
- R11: During reset every register reads zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| lid_open_i | input | 1 | Lid state, 1 = open |
| err_evt_i | input | 1 | Drive error event pulse |
| xfer_evt_i | input | 1 | Transfer complete event pulse |
| brk_evt_i | input | 1 | Break event pulse |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, an 8-bit configuration field and the three offsets 0x00, 0x04 and 0x24. With an 8-bit offset, the random stimulus can hit the unmapped offsets 0x10 and 0x28 as often as the mapped ones. Random event pulses often land in the same cycle as random write-one-to-clear writes, so the event-over-clear priority and the one-cycle interrupt delay are exercised many times over. The lid toggles rarely enough that cover-pending clears by software are seen between lid changes.

// File: rtl/disc_irq_pkg.sv
package disc_irq_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned N_ST_SRC = 3;              // error, transfer done, break
  localparam int unsigned ST_W     = 1 + 2 * N_ST_SRC;
  localparam int unsigned CV_W     = 3;
  localparam int unsigned ST_STOP  = 0;
  localparam int unsigned CV_LID   = 0;
  localparam int unsigned CV_EN    = 1;
  localparam int unsigned CV_PEND  = 2;
endpackage

// File: rtl/disc_irq_status.sv
module disc_irq_status
  import disc_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ST_W-1:0]     wdata_i,
  input  logic [N_ST_SRC-1:0] evt_i,
  output logic [ST_W-1:0]     stat_o,
  output logic [N_ST_SRC-1:0] pend_o,
  output logic [N_ST_SRC-1:0] en_o
);
  logic stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   stop_q <= 1'b0;
    else if (wr_i) stop_q <= wdata_i[ST_STOP];
  end
  assign stat_o[ST_STOP] = stop_q;

  for (genvar s = 0; s < N_ST_SRC; s++) begin : g_src
    localparam int unsigned EB = 1 + 2 * s;
    localparam int unsigned PB = 2 + 2 * s;
    logic en_q, pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (wr_i) en_q <= wdata_i[EB];
        // event has priority over a same-cycle clear
        pend_q <= evt_i[s] | (pend_q & ~(wr_i & wdata_i[PB]));
      end
    end

    assign stat_o[EB] = en_q;
    assign stat_o[PB] = pend_q;
    assign pend_o[s]  = pend_q;
    assign en_o[s]    = en_q;
  end
endmodule

// File: rtl/disc_irq_cover.sv
module disc_irq_cover
  import disc_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [CV_W-1:0] wdata_i,
  input  logic            lid_i,
  output logic [CV_W-1:0] cov_o,
  output logic            primed_o
);
  logic lid_q, en_q, pend_q, primed_q;
  logic chg;

  assign chg = primed_q & (lid_i ^ lid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lid_q    <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lid_q    <= lid_i;
      primed_q <= 1'b1;
      if (wr_i) en_q <= wdata_i[CV_EN];
      pend_q <= chg | (pend_q & ~(wr_i & wdata_i[CV_PEND]));
    end
  end

  assign cov_o[CV_LID]  = lid_q;
  assign cov_o[CV_EN]   = en_q;
  assign cov_o[CV_PEND] = pend_q;
  assign primed_o       = primed_q;

  logic unused_wbit;
  assign unused_wbit = wdata_i[CV_LID];
endmodule

// File: rtl/disc_irq_combine.sv
module disc_irq_combine #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(pend_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disc_irq_regs.sv
module disc_irq_regs
  import disc_irq_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter int unsigned        CFG_W     = 8,
  parameter logic [ADDR_W-1:0]  STAT_OFS  = 'h00,
  parameter logic [ADDR_W-1:0]  COVER_OFS = 'h04,
  parameter logic [ADDR_W-1:0]  CFG_OFS   = 'h24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              lid_open_i,
  input  logic              err_evt_i,
  input  logic              xfer_evt_i,
  input  logic              brk_evt_i,
  output logic              irq_o
);
  localparam int unsigned N_SRC = N_ST_SRC + 1;

  logic                sel_st, sel_cv, sel_cfg;
  logic [ST_W-1:0]     stat_w;
  logic [CV_W-1:0]     cov_w;
  logic [N_ST_SRC-1:0] st_pend, st_en;
  logic                cov_primed;
  logic [CFG_W-1:0]    cfg_q;

  assign sel_st  = (addr_i == STAT_OFS);
  assign sel_cv  = (addr_i == COVER_OFS);
  assign sel_cfg = (addr_i == CFG_OFS);

  disc_irq_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i & sel_st),
    .wdata_i (wdata_i[ST_W-1:0]),
    .evt_i   ({brk_evt_i, xfer_evt_i, err_evt_i}),
    .stat_o  (stat_w),
    .pend_o  (st_pend),
    .en_o    (st_en)
  );

  disc_irq_cover u_cover (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i & sel_cv),
    .wdata_i  (wdata_i[CV_W-1:0]),
    .lid_i    (lid_open_i),
    .cov_o    (cov_w),
    .primed_o (cov_primed)
  );

  disc_irq_combine #(.N(N_SRC)) u_combine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i ({cov_w[CV_PEND], st_pend}),
    .en_i   ({cov_w[CV_EN],   st_en}),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cfg_q <= '0;
    else if (wr_en_i & sel_cfg) cfg_q <= wdata_i[CFG_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_st)       rdata_o[ST_W-1:0]  = stat_w;
    else if (sel_cv)  rdata_o[CV_W-1:0]  = cov_w;
    else if (sel_cfg) rdata_o[CFG_W-1:0] = cfg_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DW-1:CFG_W];
endmodule

// File: rtl/disc_irq_regs_chk.sv
module disc_irq_regs_chk
  import disc_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] COVER_OFS = 'h04,
  parameter logic [ADDR_W-1:0] CFG_OFS   = 'h24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic              lid_open_i,
  input logic              err_evt_i,
  input logic              irq_o,
  input logic [ST_W-1:0]   stat_i,
  input logic [CV_W-1:0]   cov_i,
  input logic              primed_i
);
  logic wr_st, wr_cv, unmapped;
  assign wr_st    = wr_en_i && addr_i == STAT_OFS;
  assign wr_cv    = wr_en_i && addr_i == COVER_OFS;
  assign unmapped = addr_i != STAT_OFS && addr_i != COVER_OFS && addr_i != CFG_OFS;

  a_r1_status_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == STAT_OFS |-> rdata_o[DW-1:ST_W] == '0);

  a_r2_enable_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st |=> stat_i[0] == $past(wdata_i[0]) && stat_i[1] == $past(wdata_i[1]) &&
              stat_i[3] == $past(wdata_i[3]) && stat_i[5] == $past(wdata_i[5]));

  a_r3_err_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_st && wdata_i[2] && !err_evt_i |=> !stat_i[2]);

  a_r4_lid_not_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cv && primed_i && lid_open_i == cov_i[0] |=> cov_i[0] == $past(cov_i[0]));

  a_r5_lid_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_i && lid_open_i != cov_i[0] |=> cov_i[2] && cov_i[0] == $past(lid_open_i));

  a_r6_first_load_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |=> !cov_i[2] && cov_i[0] == $past(lid_open_i));

  a_r7_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past((stat_i[1] & stat_i[2]) | (stat_i[3] & stat_i[4]) |
                   (stat_i[5] & stat_i[6]) | (cov_i[1] & cov_i[2])));

  a_r9_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt_i |=> stat_i[2]);

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped |-> rdata_o == '0);
endmodule

bind disc_irq_regs disc_irq_regs_chk #(
  .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .COVER_OFS(COVER_OFS), .CFG_OFS(CFG_OFS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .lid_open_i (lid_open_i),
  .err_evt_i  (err_evt_i),
  .irq_o      (irq_o),
  .stat_i     (stat_w),
  .cov_i      (cov_w),
  .primed_i   (cov_primed)
);

// File: tb/disc_irq_regs_test.sv
`timescale 1ns/1ps
module disc_irq_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        lid_open_i = 1'b0;
  logic        err_evt_i = 1'b0, xfer_evt_i = 1'b0, brk_evt_i = 1'b0;
  logic        irq_o;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [6:0] m_st = '0;
  logic [2:0] m_cv = '0;
  logic [7:0] m_cfg = '0;
  logic       m_irq = 1'b0, m_primed = 1'b0;

  always #2.5 clk_i = ~clk_i;

  disc_irq_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lid_open_i(lid_open_i),
    .err_evt_i(err_evt_i), .xfer_evt_i(xfer_evt_i), .brk_evt_i(brk_evt_i),
    .irq_o(irq_o)
  );

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00:   return {25'b0, m_st};
      8'h04:   return {29'b0, m_cv};
      8'h24:   return {24'b0, m_cfg};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00:   return "R1";
      8'h04:   return "R4";
      8'h24:   return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(logic [7:0] a, string req);
    wr_en_i = 1'b0; addr_i = a; #1;
    check(req, rdata_o, m_read(a));
  endtask

  // one clock with the given stimulus; model advanced in parallel
  task automatic tick(logic w, logic [7:0] a, logic [31:0] d, logic lid,
                      logic e, logic t, logic b);
    logic [6:0] ns;
    logic [2:0] nc;
    logic [7:0] ncfg;
    logic       nirq;
    wr_en_i = w; addr_i = a; wdata_i = d; lid_open_i = lid;
    err_evt_i = e; xfer_evt_i = t; brk_evt_i = b;
    ns = m_st; nc = m_cv; ncfg = m_cfg;
    if (w && a == 8'h00) begin
      ns[0] = d[0]; ns[1] = d[1]; ns[3] = d[3]; ns[5] = d[5];
      if (d[2]) ns[2] = 1'b0;
      if (d[4]) ns[4] = 1'b0;
      if (d[6]) ns[6] = 1'b0;
    end
    if (e) ns[2] = 1'b1;
    if (t) ns[4] = 1'b1;
    if (b) ns[6] = 1'b1;
    if (w && a == 8'h04) begin
      nc[1] = d[1];
      if (d[2]) nc[2] = 1'b0;
    end
    if (!m_primed) nc[0] = lid;
    else if (lid != m_cv[0]) begin nc[0] = lid; nc[2] = 1'b1; end
    if (w && a == 8'h24) ncfg = d[7:0];
    nirq = (m_st[1] & m_st[2]) | (m_st[3] & m_st[4]) | (m_st[5] & m_st[6]) | (m_cv[1] & m_cv[2]);
    @(posedge clk_i); #1;
    m_st = ns; m_cv = nc; m_cfg = ncfg; m_irq = nirq; m_primed = 1'b1;
    wr_en_i = 1'b0; err_evt_i = 1'b0; xfer_evt_i = 1'b0; brk_evt_i = 1'b0;
    check("R7", {31'b0, irq_o}, {31'b0, m_irq});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h10, 32'h0, lid_open_i, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] addrs [5];
    addrs = '{8'h00, 8'h04, 8'h24, 8'h10, 8'h28};
    void'($urandom(32'h5eed1234));
    lid_open_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    // R11: reset state
    rd(8'h00, "R11"); rd(8'h04, "R11"); rd(8'h24, "R11");
    check("R11", {31'b0, irq_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R6: first edge loads lid=1 with no pending
    tick(1'b0, 8'h10, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(8'h04, "R6");
    check("R6", rdata_o, 32'h1);
    // R2: enables and stop bit copied, pending bits not set by writing 1
    tick(1'b1, 8'h00, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(8'h00, "R2");
    check("R2", rdata_o, 32'h2B);
    // R3 and R7: error pending, irq one cycle later
    tick(1'b0, 8'h10, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", {31'b0, irq_o}, 32'h0);
    tick(1'b0, 8'h10, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R7", {31'b0, irq_o}, 32'h1);
    tick(1'b1, 8'h00, 32'h2B, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(8'h00, "R3");
    check("R3", rdata_o, 32'h2F);
    tick(1'b1, 8'h00, 32'h2F, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(8'h00, "R3");
    check("R3", rdata_o, 32'h2B);
    // R9: event and clear in the same cycle
    tick(1'b1, 8'h00, 32'h7F, 1'b1, 1'b1, 1'b1, 1'b1);
    rd(8'h00, "R9");
    check("R9", rdata_o, 32'h7F);
    tick(1'b1, 8'h00, 32'h70, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(2);
    check("R7", {31'b0, irq_o}, 32'h0);
    // R4: lid bit not writable, enable written
    tick(1'b1, 8'h04, 32'hFFFF_FFFA, 1'b1, 1'b0, 1'b0, 1'b0);
    rd(8'h04, "R4");
    check("R4", rdata_o, 32'h3);
    // R5: lid closes -> pending, then irq
    tick(1'b0, 8'h10, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(8'h04, "R5");
    check("R5", rdata_o, 32'h6);
    idle(1);
    check("R7", {31'b0, irq_o}, 32'h1);
    tick(1'b1, 8'h04, 32'h4, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(8'h04, "R4");
    // R8: config low bits only
    tick(1'b1, 8'h24, 32'hFFFF_FFA5, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(8'h24, "R8");
    check("R8", rdata_o, 32'hA5);
    // R10: unmapped write changes nothing, reads zero
    tick(1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(8'h10, "R10"); rd(8'h00, "R10"); rd(8'h04, "R10"); rd(8'h24, "R10");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic       w, lid;
      a   = addrs[$urandom_range(0, 4)];
      w   = ($urandom_range(0, 3) == 0);
      lid = ($urandom_range(0, 31) == 0) ? ~lid_open_i : lid_open_i;
      tick(w, a, $urandom, lid, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      a = addrs[$urandom_range(0, 4)];
      rd(a, tag_of(a));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule